// File: doc/BRIEF.md
# Angular Intra Reference Sample Selector

This block feeds the linear interpolation filter of a 4×4 angular intra predictor. A start pulse loads a direction family (vertical or horizontal) and a signed angle step. The block then walks the four predicted rows. For each row it picks a five-sample window out of the corner sample, the top reference row and the left reference column. It presents that window with the row's fractional weight, the four interpolated pixels of the row and a one-cycle row strobe.

Rows whose window would reach across the corner are served straight from the side reference. No projected main-reference array is built. A detector made of a comparator and the row counter runs while the rows are produced. It marks a mode whose first row starts exactly on the corner with a nonzero fraction. In the later rows of such a mode, the side sample next to the corner is skipped.

Top module: `intra_ref_sel`

## Requirements
- R1: A start pulse is accepted only while the block is idle; it latches `vert_i` and `angle_i`. A start pulse during a running block is ignored: rows keep the first mode, and no extra rows follow `done_o`.
- R2: Taking the edge that accepts start as edge 0, row r (0..3) has `row_valid_o` high for exactly the one cycle after edge 8+5r. `done_o` is high for exactly the one cycle after edge 24, which is the cycle after the last row. The two are never high together.
- R3: For row r the intercept is p = angle·(r+1). `frac_o` = p mod 32 (its low 5 bits), `row_idx_o` = r, and the lead index is floor(p/32)+1.
- R4: Window slot j (0..4, bits [8j+7:8j] of `win_o`) takes index k = lead+j. The main reference is the top row when `vert_i`=1 and the left column when `vert_i`=0; the side reference is the other one. k>0 gives main sample k, k=0 gives the corner, and k<0 gives side sample −k. Sample n (1..8) of `top_i`/`left_i` sits at bits [8n−1:8n−8], and an index beyond 8 yields 0.
- R5: A mode is flagged when its row 0 has a nonzero fraction and lead index 0, which means angles −31..−1. Row 0 itself is never altered.
- R6: In a flagged mode, a later row whose fraction is nonzero and whose lead index is not 0 skips side sample 1: k<0 gives side sample −k+1.
- R7: In a flagged mode, a row whose fraction is zero uses the plain window of R4.
- R8: Unflagged modes (angle −32, 0 and positive angles) always use the plain window of R4.
- R9: Pixel x (0..3, bits [8x+7:8x] of `pred_o`) = ((32−f)·slot[x] + f·slot[x+1] + 16) >> 5.
- R10: During and right after reset, all outputs are zero.
- R11: Reference inputs are read at each row's edge, so a reference change between rows shows up in the following rows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start of a block |
| vert_i | input | 1 | 1: vertical family, 0: horizontal family |
| angle_i | input | 6 | Signed angle step in 1/32 sample units |
| corner_i | input | 8 | Corner reference sample |
| top_i | input | 64 | Top reference samples 1..8 |
| left_i | input | 64 | Left reference samples 1..8 |
| row_valid_o | output | 1 | Row outputs valid |
| row_idx_o | output | 2 | Row number |
| frac_o | output | 5 | Fractional weight of the row |
| win_o | output | 40 | Five selected samples |
| pred_o | output | 32 | Four interpolated pixels |
| done_o | output | 1 | Block finished |

## Verification
The bench aims at the angles that straddle the corner. Angle −13 and angle −21 must skip side sample 1 in later rows. A design without the skip would repeat the corner-adjacent side sample and shift each negative slot by one. Angle −16 mixes zero and nonzero fractions, and angle −32 starts a row on the corner with no fraction. A design that skipped on zero fractions, or flagged on the corner alone, would corrupt those windows. A second start during a block, and a reference change between rows, catch a design that restarts the walk or caches references at start.

// File: rtl/intra_ref_pkg.sv
package intra_ref_pkg;
  localparam int FRAC_BITS = 5;
  typedef enum logic {FAM_HORZ = 1'b0, FAM_VERT = 1'b1} fam_e;
endpackage

// File: rtl/intra_row_seq.sv
module intra_row_seq #(
  parameter int N          = 4,
  parameter int ANGW       = 6,
  parameter int PW         = 9,
  parameter int FIRST_LAT  = 8,
  parameter int ROW_PERIOD = 5,
  localparam int RW        = $clog2(N)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  logic                   fam_i,
  input  logic signed [ANGW-1:0] angle_i,
  output logic                   load_o,
  output logic                   emit_o,
  output logic                   done_o,
  output logic [RW-1:0]          row_o,
  output logic signed [PW-1:0]   icpt_o,
  output logic                   fam_o
);
  localparam int DONE_AT = FIRST_LAT + (N-1)*ROW_PERIOD + 1;
  localparam int CW      = $clog2(FIRST_LAT + N*ROW_PERIOD + 1);

  logic                   busy_q, fam_q;
  logic [CW-1:0]          cnt_q, next_q;
  logic [RW-1:0]          row_q;
  logic signed [PW-1:0]   acc_q;
  logic signed [ANGW-1:0] ang_q;

  assign load_o = !busy_q && start_i;
  assign emit_o = busy_q && (cnt_q == next_q);
  assign done_o = busy_q && (cnt_q == CW'(DONE_AT));
  assign row_o  = row_q;
  assign icpt_o = acc_q;
  assign fam_o  = fam_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      fam_q  <= 1'b0;
      cnt_q  <= '0;
      next_q <= '0;
      row_q  <= '0;
      acc_q  <= '0;
      ang_q  <= '0;
    end else if (load_o) begin
      busy_q <= 1'b1;
      fam_q  <= fam_i;
      cnt_q  <= CW'(1);
      next_q <= CW'(FIRST_LAT);
      row_q  <= '0;
      acc_q  <= PW'(angle_i);
      ang_q  <= angle_i;
    end else if (busy_q) begin
      cnt_q <= cnt_q + CW'(1);
      if (emit_o) begin
        row_q  <= row_q + RW'(1);
        acc_q  <= acc_q + PW'(ang_q);
        next_q <= next_q + CW'(ROW_PERIOD);
      end
      if (done_o) busy_q <= 1'b0;
    end
  end
endmodule

// File: rtl/intra_disc_det.sv
module intra_disc_det #(
  parameter int PW = 9,
  parameter int FB = intra_ref_pkg::FRAC_BITS
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 load_i,
  input  logic                 emit_i,
  input  logic                 first_row_i,
  input  logic [FB-1:0]        frac_i,
  input  logic signed [PW-1:0] lead_i,
  output logic                 skip_o
);
  logic flag_q;
  logic on_corner;

  assign on_corner = (lead_i == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     flag_q <= 1'b0;
    else if (load_i)                 flag_q <= 1'b0;
    else if (emit_i && first_row_i)  flag_q <= (frac_i != '0) && on_corner;
  end

  // skip only in later rows that start off the corner with a fraction
  assign skip_o = flag_q && !first_row_i && !on_corner && (frac_i != '0);
endmodule

// File: rtl/intra_ref_pick.sv
module intra_ref_pick #(
  parameter int N    = 4,
  parameter int SW   = 8,
  parameter int NREF = 8,
  parameter int PW   = 9,
  localparam int WIN = N + 1
) (
  input  logic                 fam_i,
  input  logic                 skip_i,
  input  logic signed [PW-1:0] lead_i,
  input  logic [SW-1:0]        corner_i,
  input  logic [NREF*SW-1:0]   top_i,
  input  logic [NREF*SW-1:0]   left_i,
  output logic [WIN*SW-1:0]    win_o
);
  logic [NREF*SW-1:0] main_ref, side_ref;

  assign main_ref = fam_i ? top_i  : left_i;
  assign side_ref = fam_i ? left_i : top_i;

  for (genvar j = 0; j < WIN; j++) begin : g_slot
    always_comb begin
      int k;
      int m;
      k = int'(lead_i) + j;
      m = -k + (skip_i ? 1 : 0);
      win_o[j*SW +: SW] = '0;
      if (k == 0) begin
        win_o[j*SW +: SW] = corner_i;
      end else if (k > 0) begin
        if (k <= NREF) win_o[j*SW +: SW] = main_ref[(k-1)*SW +: SW];
      end else begin
        if (m <= NREF) win_o[j*SW +: SW] = side_ref[(m-1)*SW +: SW];
      end
    end
  end
endmodule

// File: rtl/intra_interp.sv
module intra_interp #(
  parameter int N  = 4,
  parameter int SW = 8,
  parameter int FB = intra_ref_pkg::FRAC_BITS,
  localparam int WIN = N + 1
) (
  input  logic [WIN*SW-1:0] win_i,
  input  logic [FB-1:0]     frac_i,
  output logic [N*SW-1:0]   pred_o
);
  localparam int AW  = SW + FB + 1;
  localparam int ONE = 1 << FB;

  logic [FB:0] wgt_a;
  assign wgt_a = (FB+1)'(ONE) - {1'b0, frac_i};

  for (genvar x = 0; x < N; x++) begin : g_pix
    logic [AW-1:0] sum;
    assign sum = AW'(win_i[x*SW +: SW]) * AW'(wgt_a)
               + AW'(win_i[(x+1)*SW +: SW]) * AW'(frac_i)
               + AW'(ONE/2);
    assign pred_o[x*SW +: SW] = sum[FB +: SW];
  end
endmodule

// File: rtl/intra_ref_sel.sv
module intra_ref_sel #(
  parameter int N          = 4,
  parameter int SW         = 8,
  parameter int NREF       = 2*N,
  parameter int ANGW       = 6,
  parameter int FIRST_LAT  = 8,
  parameter int ROW_PERIOD = 5,
  localparam int FB  = intra_ref_pkg::FRAC_BITS,
  localparam int WIN = N + 1,
  localparam int RW  = $clog2(N),
  localparam int PW  = ANGW + $clog2(N) + 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  logic                   vert_i,
  input  logic signed [ANGW-1:0] angle_i,
  input  logic [SW-1:0]          corner_i,
  input  logic [NREF*SW-1:0]     top_i,
  input  logic [NREF*SW-1:0]     left_i,
  output logic                   row_valid_o,
  output logic [RW-1:0]          row_idx_o,
  output logic [FB-1:0]          frac_o,
  output logic [WIN*SW-1:0]      win_o,
  output logic [N*SW-1:0]        pred_o,
  output logic                   done_o
);
  logic                 load, emit, done, fam, skip;
  logic [RW-1:0]        row;
  logic signed [PW-1:0] icpt, ipart, lead;
  logic [FB-1:0]        frac;
  logic [WIN*SW-1:0]    win;
  logic [N*SW-1:0]      pred;

  assign frac  = icpt[FB-1:0];
  assign ipart = icpt >>> FB;
  assign lead  = ipart + $signed(PW'(1));

  intra_row_seq #(.N(N), .ANGW(ANGW), .PW(PW), .FIRST_LAT(FIRST_LAT),
                  .ROW_PERIOD(ROW_PERIOD)) u_seq (
    .clk_i, .rst_ni, .start_i, .fam_i(vert_i), .angle_i,
    .load_o(load), .emit_o(emit), .done_o(done), .row_o(row),
    .icpt_o(icpt), .fam_o(fam)
  );

  intra_disc_det #(.PW(PW), .FB(FB)) u_det (
    .clk_i, .rst_ni, .load_i(load), .emit_i(emit),
    .first_row_i(row == '0), .frac_i(frac), .lead_i(lead), .skip_o(skip)
  );

  intra_ref_pick #(.N(N), .SW(SW), .NREF(NREF), .PW(PW)) u_pick (
    .fam_i(fam), .skip_i(skip), .lead_i(lead), .corner_i,
    .top_i, .left_i, .win_o(win)
  );

  intra_interp #(.N(N), .SW(SW), .FB(FB)) u_interp (
    .win_i(win), .frac_i(frac), .pred_o(pred)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_valid_o <= 1'b0;
      done_o      <= 1'b0;
      row_idx_o   <= '0;
      frac_o      <= '0;
      win_o       <= '0;
      pred_o      <= '0;
    end else begin
      row_valid_o <= emit;
      done_o      <= done;
      if (emit) begin
        row_idx_o <= row;
        frac_o    <= frac;
        win_o     <= win;
        pred_o    <= pred;
      end
    end
  end
endmodule

// File: rtl/intra_ref_sel_chk.sv
module intra_ref_sel_chk #(
  parameter int N  = 4,
  parameter int SW = 8,
  parameter int RW = 2,
  parameter int FB = 5
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 row_valid_o,
  input logic [RW-1:0]        row_idx_o,
  input logic [FB-1:0]        frac_o,
  input logic [(N+1)*SW-1:0]  win_o,
  input logic [N*SW-1:0]      pred_o,
  input logic                 done_o
);
  a_r2_valid_done_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(row_valid_o && done_o));

  a_r2_row_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    row_valid_o |=> !row_valid_o);

  a_r2_done_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (row_valid_o && row_idx_o == RW'(N-1)) |=> done_o);

  a_r2_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  for (genvar x = 0; x < N; x++) begin : g_chk
    a_r9_zero_frac_copy: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (row_valid_o && frac_o == '0) |-> pred_o[x*SW +: SW] == win_o[x*SW +: SW]);
  end
endmodule

bind intra_ref_sel intra_ref_sel_chk #(.N(N), .SW(SW), .RW(RW), .FB(FB)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .row_valid_o(row_valid_o),
  .row_idx_o(row_idx_o), .frac_o(frac_o), .win_o(win_o),
  .pred_o(pred_o), .done_o(done_o)
);

// File: tb/sim_intra_ref_sel.sv
`timescale 1ns/1ps
module sim_intra_ref_sel;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic        vert_i = 1'b0;
  logic signed [5:0] angle_i = '0;
  logic [7:0]  corner_i;
  logic [63:0] top_i, left_i;
  logic        row_valid_o, done_o;
  logic [1:0]  row_idx_o;
  logic [4:0]  frac_o;
  logic [39:0] win_o;
  logic [31:0] pred_o;

  int checks = 0;
  int errors = 0;

  logic [7:0] tb_corner;
  logic [7:0] tb_top  [1:8];
  logic [7:0] tb_left [1:8];

  always #10 clk = ~clk;

  always_comb begin
    corner_i = tb_corner;
    for (int n = 1; n <= 8; n++) begin
      top_i[(n-1)*8 +: 8]  = tb_top[n];
      left_i[(n-1)*8 +: 8] = tb_left[n];
    end
  end

  intra_ref_sel u0 (
    .clk_i(clk), .rst_ni, .start_i, .vert_i, .angle_i, .corner_i,
    .top_i, .left_i, .row_valid_o, .row_idx_o, .frac_o, .win_o,
    .pred_o, .done_o
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic load_refs(input int set);
    tb_corner = (set == 0) ? 8'h80 : 8'h3c;
    for (int n = 1; n <= 8; n++) begin
      tb_top[n]  = (set == 0) ? 8'(8'h10 + n*9)  : 8'(8'hf0 - n*11);
      tb_left[n] = (set == 0) ? 8'(8'hc0 + n*5)  : 8'(8'h05 + n*17);
    end
  endtask

  function automatic logic [7:0] ref_at(bit vert, int k, bit skip);
    int m;
    if (k == 0) return tb_corner;
    if (k > 0) return (k <= 8) ? (vert ? tb_top[k] : tb_left[k]) : 8'h00;
    m = -k + (skip ? 1 : 0);
    return (m <= 8) ? (vert ? tb_left[m] : tb_top[m]) : 8'h00;
  endfunction

  // runs one block; busy_kick issues a conflicting start, upd swaps refs after row 0
  task automatic run_mode(input bit vert, input int angle, input bit busy_kick,
                          input bit upd);
    bit stray_valid = 0;
    bit early_done  = 0;
    bit flagged     = (angle >= -31) && (angle <= -1);
    @(negedge clk);
    start_i = 1'b1; vert_i = vert; angle_i = 6'(angle);
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    for (int c = 1; c <= 24; c++) begin
      @(posedge clk);
      @(negedge clk);
      if (busy_kick && c == 3) begin
        start_i = 1'b1; vert_i = !vert; angle_i = 6'(7);
      end
      if (busy_kick && c == 4) start_i = 1'b0;
      if (upd && c == 10) load_refs(1);
      if (c >= 8 && (c - 8) % 5 == 0 && c < 28) begin
        int r = (c - 8) / 5;
        int p = angle * (r + 1);
        int f = p & 31;
        int lead = (p >>> 5) + 1;
        bit skip = (r > 0) && flagged && (lead != 0) && (f != 0);
        logic [7:0] w [0:4];
        logic [39:0] wexp;
        logic [31:0] pexp;
        string tag;
        for (int j = 0; j < 5; j++) begin
          w[j] = ref_at(vert, lead + j, skip);
          wexp[j*8 +: 8] = w[j];
        end
        for (int x = 0; x < 4; x++)
          pexp[x*8 +: 8] = 8'(((32 - f) * w[x] + f * w[x+1] + 16) >> 5);
        if (upd && r > 0)      tag = "R11";
        else if (skip)         tag = "R6";
        else if (flagged && r == 0) tag = "R5";
        else if (flagged)      tag = "R7";
        else if (angle < 0)    tag = "R8";
        else                   tag = "R4";
        chk(row_valid_o && row_idx_o == 2'(r), "R2", "row strobe/index",
            {row_valid_o, row_idx_o}, {1'b1, 2'(r)});
        chk(frac_o == 5'(f), "R3", "frac", frac_o, f);
        chk(win_o == wexp, tag, "window", win_o, wexp);
        chk(pred_o == pexp, "R9", "pred", pred_o, pexp);
      end else if (row_valid_o) stray_valid = 1;
      if (c < 24 && done_o) early_done = 1;
      if (c == 24) chk(done_o && !row_valid_o, "R2", "done after last row",
                       done_o, 1);
    end
    chk(!stray_valid && !early_done, "R2", "no strobe off schedule",
        {stray_valid, early_done}, 0);
    for (int c = 0; c < 6; c++) begin
      @(posedge clk);
      @(negedge clk);
      if (row_valid_o || done_o) stray_valid = 1;
    end
    chk(!stray_valid, busy_kick ? "R1" : "R2", "quiet after done",
        stray_valid, 0);
    if (upd) load_refs(0);
  endtask

  task automatic t_reset();
    load_refs(0);
    rst_ni = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!row_valid_o && !done_o && win_o == '0 && pred_o == '0 &&
        frac_o == '0 && row_idx_o == '0, "R10", "reset outputs",
        {row_valid_o, done_o, win_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(!row_valid_o && !done_o, "R10", "idle after reset",
        {row_valid_o, done_o}, 0);
  endtask

  task automatic t_positive();   run_mode(1, 13, 0, 0); run_mode(0, 31, 0, 0); endtask
  task automatic t_zero_angle(); run_mode(1, 0, 0, 0);  run_mode(0, 0, 0, 0);  endtask
  task automatic t_flag_vert();  run_mode(1, -13, 0, 0); run_mode(1, -1, 0, 0); endtask
  task automatic t_flag_horz();  run_mode(0, -21, 0, 0); run_mode(0, -31, 0, 0); endtask
  task automatic t_flag_zero_frac(); run_mode(1, -16, 0, 0); run_mode(0, -8, 0, 0); endtask
  task automatic t_unflagged_neg();  run_mode(1, -32, 0, 0); run_mode(0, -32, 0, 0); endtask
  task automatic t_busy_start(); run_mode(1, -13, 1, 0); endtask
  task automatic t_ref_update(); run_mode(0, -21, 0, 1); run_mode(1, 19, 0, 1); endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_positive();
    t_zero_angle();
    t_flag_vert();
    t_flag_horz();
    t_flag_zero_frac();
    t_unflagged_neg();
    t_busy_start();
    t_ref_update();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule